// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache with LRU Replacement

This block sits between a processor and a word-addressed main memory. It holds 64 sets of two lines each, and each line holds 16 data words. A request gives a 16-bit word address. The block looks up the set that the address names, compares the tags of both ways in the same cycle, and serves a hit straight from its data store. A write hit changes only the cached copy and marks the line as modified.

On a miss, the controller picks a victim way. A modified victim is first copied back to memory one word at a time. The missing line is then fetched one word at a time, and the original request is looked up again, so that it completes as a hit. Writes that miss follow the same path: the line is fetched first and the write is then applied to it. The processor holds its request until the block pulses a completion strobe. The memory side uses a request/acknowledge handshake with one acknowledge per word.

The controller has four states. IDLE accepts a request and latches it (transition *accept*). LOOKUP either finishes the request (*hit*) or leaves on a miss: it goes to EVICT when the victim is modified (*dirty_miss*) and to FILL otherwise (*clean_miss*). EVICT sends 16 words to memory and then moves on to FILL (*evict_done*). FILL reads 16 words, installs the new tag and returns to LOOKUP (*fill_done*).

Top module: `twoway_lru_cache`

## Requirements
- R1: A word address splits into tag = bits 15:10, set = bits 9:4 and word = bits 3:0. For example, address 0x357A is tag 13, set 23, word 10, and a modified line holding it is written back to memory word 0x357A.
- R2: A hit completes with a single-cycle `cpu_done` pulse in the cycle after the request is accepted. The same cycle carries the read data. Counted in falling clock edges after the request is raised, the pulse is seen at edge 1.
- R3: A read always returns the value most recently written to that address by the processor, or the memory's content if the processor never wrote it, whatever evictions happened in between.
- R4: Both ways of a set are searched. Two lines whose tags differ but that map to the same set stay cached together and both hit.
- R5: On a miss, an empty way is filled first, and way 0 is chosen when both ways are empty. When both ways are occupied, the least recently used way is replaced.
- R6: Every read hit, write hit and line fill makes the touched way the most recently used way of its set.
- R7: A write marks its line as modified. Before a modified victim is replaced, its 16 words go to memory at addresses {stored tag, set, 0..15}, in ascending word order. A miss with a modified victim completes at falling edge 66.
- R8: A miss whose victim is not modified writes nothing to memory and completes at falling edge 34. While a memory request waits for its acknowledge, the memory address is held steady.
- R9: A write that misses first fetches the whole line from memory and then writes the one word. The other 15 words of the line read back with their memory values.
- R10: In a lookup, at most one way's tag matches.
- R11: After reset, every line is empty, `cpu_done` and `mem_req` are low, and the first access to any address is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request; held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read data, valid with `cpu_done` |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write-back word, 0 = fill read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write-back data |
| mem_ack | input | 1 | One-cycle acknowledge per word |
| mem_rdata | input | 16 | Fill data, valid with `mem_ack` |

## Verification
Directed sequences cover the cases that only a particular ordering can separate:
- the 0x357A decode, confirmed by the memory address a dirty eviction writes to;
- two tags sharing one set, which tells a real two-way search from a direct-mapped one;
- a touch-then-conflict order, which tells LRU from FIFO or fixed-way replacement;
- a write miss, which shows whether the rest of the line was fetched.

Seeded random traffic, confined to four tags and four sets, then forces frequent conflicts. Every completion time is compared against a reference model of tags, modified flags and LRU bits, which separates hits, clean misses and dirty misses. Read data is compared against a golden image of memory.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LOOKUP = 2'd1,
        S_EVICT  = 2'd2,
        S_FILL   = 2'd3
    } cstate_t;

endpackage

// File: rtl/cache2w_tags.sv
module cache2w_tags
    import cache2w_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int SET_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            look_set,
    output logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    output logic [WAYS-1:0]             way_pres,
    output logic [WAYS-1:0]             way_mod,
    output logic                        lru_way,
    input  logic                        fill_en,
    input  logic                        fill_way,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic                        mark_en,
    input  logic                        mark_way,
    input  logic                        touch_en,
    input  logic                        touch_way
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0] lru_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_q [SETS];
        logic [SETS-1:0]  pres_q;
        logic [SETS-1:0]  mod_q;

        always_ff @(posedge clk) begin
            if (fill_en && (fill_way == w[0])) begin
                tag_q[look_set] <= fill_tag;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pres_q <= '0;
                mod_q  <= '0;
            end else if (fill_en && (fill_way == w[0])) begin
                pres_q[look_set] <= 1'b1;
                mod_q[look_set]  <= 1'b0;
            end else if (mark_en && (mark_way == w[0])) begin
                mod_q[look_set]  <= 1'b1;
            end
        end

        assign way_tag[w]  = tag_q[look_set];
        assign way_pres[w] = pres_q[look_set];
        assign way_mod[w]  = mod_q[look_set];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (touch_en) begin
            lru_q[look_set] <= ~touch_way;
        end
    end

    assign lru_way = lru_q[look_set];

endmodule

// File: rtl/cache2w_data.sv
module cache2w_data
    import cache2w_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SET_W  = 6,
    parameter int OFF_W  = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_way,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << (SET_W + OFF_W);

    logic [WAYS-1:0][DATA_W-1:0] way_word;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [DATA_W-1:0] arr [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == w[0])) begin
                arr[{wr_set, wr_off}] <= wr_data;
            end
        end

        assign way_word[w] = arr[{rd_set, rd_off}];
    end

    assign rd_data = way_word[rd_way];

endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int SET_W  = 6,
    parameter int OFF_W  = 4
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        cpu_req,
    input  logic                                        cpu_we,
    input  logic [ADDR_W-1:0]                           cpu_addr,
    input  logic [DATA_W-1:0]                           cpu_wdata,
    output logic                                        cpu_done,
    input  logic [WAYS-1:0]                             hit_vec,
    input  logic [WAYS-1:0][ADDR_W-SET_W-OFF_W-1:0]     way_tag,
    input  logic [WAYS-1:0]                             way_pres,
    input  logic [WAYS-1:0]                             way_mod,
    input  logic                                        lru_way,
    output logic [SET_W-1:0]                            req_set,
    output logic [ADDR_W-SET_W-OFF_W-1:0]               req_tag,
    output logic                                        fill_en,
    output logic                                        mark_en,
    output logic                                        mark_way,
    output logic                                        touch_en,
    output logic                                        touch_way,
    output logic                                        dwr_en,
    output logic                                        dwr_way,
    output logic [OFF_W-1:0]                            dwr_off,
    output logic [DATA_W-1:0]                           dwr_data,
    output logic                                        drd_way,
    output logic [OFF_W-1:0]                            drd_off,
    input  logic [DATA_W-1:0]                           drd_data,
    output logic                                        fill_way,
    output logic                                        mem_req,
    output logic                                        mem_we,
    output logic [ADDR_W-1:0]                           mem_addr,
    output logic [DATA_W-1:0]                           mem_wdata,
    input  logic                                        mem_ack,
    input  logic [DATA_W-1:0]                           mem_rdata
);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_BEAT = '1;
    localparam logic [OFF_W-1:0] ONE_BEAT  = OFF_W'(1);

    cstate_t state, state_nx;

    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [OFF_W-1:0]  beat_q;
    logic              vway_q;
    logic [TAG_W-1:0]  vtag_q;

    logic hit, hit_way, vsel, needs_wb;
    logic [OFF_W-1:0] req_off;

    assign req_tag = addr_q[ADDR_W-1 -: TAG_W];
    assign req_set = addr_q[OFF_W +: SET_W];
    assign req_off = addr_q[OFF_W-1:0];

    assign hit     = |hit_vec;
    assign hit_way = hit_vec[1];

    // victim: empty way 0, then empty way 1, then the LRU way
    always_comb begin
        if (!way_pres[0]) begin
            vsel = 1'b0;
        end else if (!way_pres[1]) begin
            vsel = 1'b1;
        end else begin
            vsel = lru_way;
        end
    end

    assign needs_wb = way_pres[vsel] && way_mod[vsel];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (cpu_req) state_nx = S_LOOKUP;
            S_LOOKUP: begin
                if (hit)           state_nx = S_IDLE;
                else if (needs_wb) state_nx = S_EVICT;
                else               state_nx = S_FILL;
            end
            S_EVICT:  if (mem_ack && beat_q == LAST_BEAT) state_nx = S_FILL;
            S_FILL:   if (mem_ack && beat_q == LAST_BEAT) state_nx = S_LOOKUP;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            beat_q  <= '0;
            vway_q  <= 1'b0;
            vtag_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (cpu_req) begin
                        addr_q  <= cpu_addr;
                        we_q    <= cpu_we;
                        wdata_q <= cpu_wdata;
                    end
                end
                S_LOOKUP: begin
                    if (!hit) begin
                        vway_q <= vsel;
                        vtag_q <= way_tag[vsel];
                        beat_q <= '0;
                    end
                end
                S_EVICT, S_FILL: begin
                    if (mem_ack) beat_q <= beat_q + ONE_BEAT;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        cpu_done  = 1'b0;
        fill_en   = 1'b0;
        fill_way  = vway_q;
        mark_en   = 1'b0;
        mark_way  = hit_way;
        touch_en  = 1'b0;
        touch_way = hit_way;
        dwr_en    = 1'b0;
        dwr_way   = hit_way;
        dwr_off   = req_off;
        dwr_data  = wdata_q;
        drd_way   = hit_way;
        drd_off   = req_off;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {req_tag, req_set, beat_q};
        mem_wdata = drd_data;
        unique case (state)
            S_IDLE: begin
            end
            S_LOOKUP: begin
                if (hit) begin
                    cpu_done = 1'b1;
                    touch_en = 1'b1;
                    if (we_q) begin
                        dwr_en  = 1'b1;
                        mark_en = 1'b1;
                    end
                end
            end
            S_EVICT: begin
                drd_way  = vway_q;
                drd_off  = beat_q;
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {vtag_q, req_set, beat_q};
            end
            S_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    dwr_en   = 1'b1;
                    dwr_way  = vway_q;
                    dwr_off  = beat_q;
                    dwr_data = mem_rdata;
                    if (beat_q == LAST_BEAT) begin
                        fill_en   = 1'b1;
                        touch_en  = 1'b1;
                        touch_way = vway_q;
                    end
                end
            end
        endcase
    end

    // R10
    one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOOKUP) |-> $onehot0(hit_vec));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R7
    wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EVICT && mem_ack && beat_q != LAST_BEAT)
        |=> (state == S_EVICT && beat_q == $past(beat_q) + ONE_BEAT));

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: rtl/twoway_lru_cache.sv
module twoway_lru_cache
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int SET_W  = 6,
    parameter int OFF_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;

    logic [WAYS-1:0][TAG_W-1:0] way_tag;
    logic [WAYS-1:0]            way_pres, way_mod, hit_vec;
    logic                       lru_way;
    logic [SET_W-1:0]           req_set;
    logic [TAG_W-1:0]           req_tag;
    logic fill_en, fill_way, mark_en, mark_way, touch_en, touch_way;
    logic dwr_en, dwr_way, drd_way;
    logic [OFF_W-1:0]  dwr_off, drd_off;
    logic [DATA_W-1:0] dwr_data, drd_data;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_pres[w] && (way_tag[w] == req_tag);
    end

    cache2w_tags #(.TAG_W(TAG_W), .SET_W(SET_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .look_set(req_set),
        .way_tag(way_tag), .way_pres(way_pres), .way_mod(way_mod), .lru_way(lru_way),
        .fill_en(fill_en), .fill_way(fill_way), .fill_tag(req_tag),
        .mark_en(mark_en), .mark_way(mark_way),
        .touch_en(touch_en), .touch_way(touch_way)
    );

    cache2w_data #(.DATA_W(DATA_W), .SET_W(SET_W), .OFF_W(OFF_W)) u_data (
        .clk(clk), .wr_en(dwr_en), .wr_way(dwr_way), .wr_set(req_set),
        .wr_off(dwr_off), .wr_data(dwr_data),
        .rd_way(drd_way), .rd_set(req_set), .rd_off(drd_off), .rd_data(drd_data)
    );

    cache2w_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_W(SET_W), .OFF_W(OFF_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done),
        .hit_vec(hit_vec), .way_tag(way_tag), .way_pres(way_pres), .way_mod(way_mod),
        .lru_way(lru_way), .req_set(req_set), .req_tag(req_tag),
        .fill_en(fill_en), .mark_en(mark_en), .mark_way(mark_way),
        .touch_en(touch_en), .touch_way(touch_way),
        .dwr_en(dwr_en), .dwr_way(dwr_way), .dwr_off(dwr_off), .dwr_data(dwr_data),
        .drd_way(drd_way), .drd_off(drd_off), .drd_data(drd_data),
        .fill_way(fill_way),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    assign cpu_rdata = drd_data;

    // R7
    write_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && mark_en) |=> way_mod[$past(mark_way)]);

    // R6
    fill_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (way_pres[$past(fill_way)] && lru_way != $past(fill_way)));

endmodule

// File: tb/twoway_lru_cache_tb.sv
`timescale 1ns/1ps
module twoway_lru_cache_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_done;
    logic [15:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    twoway_lru_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] init_word(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h1234;
    endfunction

    // memory model
    logic [15:0] mem_model [logic [15:0]];
    logic [15:0] wb_log [16];
    int          wb_total = 0;

    function automatic logic [15:0] mem_get(input logic [15:0] a);
        if (mem_model.exists(a)) return mem_model[a];
        return init_word(a);
    endfunction

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (rst_n && mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem_model[mem_addr] = mem_wdata;
                wb_log[wb_total % 16] <= mem_addr;
                wb_total <= wb_total + 1;
            end else begin
                mem_rdata <= mem_get(mem_addr);
            end
        end
    end

    // golden processor view and reference tag model
    logic [15:0] gold [logic [15:0]];
    logic [5:0]  rtag [2][64];
    bit          rpres [2][64];
    bit          rmod [2][64];
    bit          rlru [64];

    function automatic logic [15:0] gold_get(input logic [15:0] a);
        if (gold.exists(a)) return gold[a];
        return init_word(a);
    endfunction

    // 0 = hit, 1 = clean miss, 2 = dirty miss
    task automatic ref_access(input logic [15:0] a, input bit we, output int cls);
        int s;
        logic [5:0] t;
        int v;
        s = int'(a[9:4]);
        t = a[15:10];
        cls = -1;
        for (int w = 0; w < 2; w++) begin
            if (rpres[w][s] && rtag[w][s] == t) begin
                rlru[s] = (w == 0);
                if (we) rmod[w][s] = 1;
                cls = 0;
            end
        end
        if (cls < 0) begin
            if (!rpres[0][s])      v = 0;
            else if (!rpres[1][s]) v = 1;
            else                   v = rlru[s] ? 1 : 0;
            cls = (rpres[v][s] && rmod[v][s]) ? 2 : 1;
            rtag[v][s]  = t;
            rpres[v][s] = 1;
            rmod[v][s]  = we;
            rlru[s]     = (v == 0);
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int cls_lat(input int c);
        return (c == 0) ? 1 : (c == 1) ? 34 : 66;
    endfunction

    task automatic do_op(input bit we, input logic [15:0] a, input logic [15:0] wd,
                         input int exp_cls, input string req);
        int n, cls, use_cls;
        logic [15:0] rd;
        ref_access(a, we, cls);
        use_cls = (exp_cls >= 0) ? exp_cls : cls;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_done && n < 200);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        check(n == cls_lat(use_cls),
              (use_cls == 0) ? {req, " R2 latency"} : (use_cls == 1) ? {req, " R8 latency"} : {req, " R7 latency"},
              n, cls_lat(use_cls));
        if (we) begin
            gold[a] = wd;
        end else begin
            check(rd == gold_get(a), {req, " R3 data"}, rd, gold_get(a));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int s;
        void'($urandom(32'h00C0FFEE));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(cpu_done == 1'b0, "R11 done", cpu_done, 0);
        check(mem_req == 1'b0, "R11 memreq", mem_req, 0);

        // R11 first access misses; R1 decode path
        do_op(0, 16'h357A, 16'h0, 1, "R11");
        do_op(0, 16'h357B, 16'h0, 0, "R2");
        do_op(1, 16'h357A, 16'hBEEF, 0, "R1");
        do_op(0, 16'h0570, 16'h0, 1, "R5");      // empty way 1 filled
        s = wb_total;
        do_op(0, 16'h0970, 16'h0, 2, "R7");      // LRU way 0 is modified
        check(wb_total == s + 16, "R7 wb count", wb_total, s + 16);
        for (int i = 0; i < 16; i++) begin
            check(wb_log[(s + i) % 16] == (16'h3570 + 16'(i)), "R7 wb addr",
                  wb_log[(s + i) % 16], 16'h3570 + 16'(i));
        end
        check(mem_get(16'h357A) == 16'hBEEF, "R1 decode", mem_get(16'h357A), 16'hBEEF);
        do_op(0, 16'h0570, 16'h0, 0, "R4");
        s = wb_total;
        do_op(0, 16'h357A, 16'h0, 1, "R3");      // clean victim, refetch written value
        check(wb_total == s, "R8 no wb", wb_total, s);

        // R6 LRU order in set 5
        do_op(0, 16'h0050, 16'h0, 1, "R6");
        do_op(0, 16'h0450, 16'h0, 1, "R6");
        do_op(0, 16'h0051, 16'h0, 0, "R6");
        do_op(0, 16'h0850, 16'h0, 1, "R6");
        do_op(0, 16'h0052, 16'h0, 0, "R6");
        do_op(0, 16'h0453, 16'h0, 1, "R6");

        // R9 write miss allocates
        do_op(1, 16'h0C65, 16'h1111, 1, "R9");
        do_op(0, 16'h0C66, 16'h0, 0, "R9");
        do_op(0, 16'h0C65, 16'h0, 0, "R9");

        // random traffic on four tags x four sets
        for (int k = 0; k < 400; k++) begin
            logic [15:0] a;
            bit w;
            a = {4'b0, 2'($urandom % 4), 4'b0, 2'($urandom % 4), 4'($urandom % 16)};
            w = ($urandom % 10) < 4;
            do_op(w, a, 16'($urandom), -1, "R5 rnd");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule